// File: doc/BRIEF.md
# Receive Elastic Store with Frame Slip

This block sits between a recovered line byte stream and a system backplane. It stores two whole frames of 32 channel bytes each, 64 locations in all. The line side writes one byte per write strobe. The system side takes one byte per read strobe. Both strobes are enables inside a single fast clock domain. When the two rates are locked, every write is matched by a read, and the separation between the write and read positions stays near its start-up value.

When the rates drift apart, the separation creeps toward one edge of a safe band. On the read that finds it outside the band, the read position jumps by exactly one frame. This is a controlled slip. If the writer is slow, the last frame is delivered a second time. If the writer is fast, one frame is skipped. Because the jump is a whole frame, channel numbering is never disturbed. Each slip is flagged with a single-cycle pulse and a held direction bit. The gap between the thresholds and the landing positions gives eight channels of jitter tolerance in either direction.

Top module: `elastic_slip_buffer`

## Requirements
- R1: While reset is asserted and right after it, rd_valid, slip_pulse, slip_repeat and rd_data are all 0.
- R2: Read strobes are ignored until 10 bytes have been written since reset. An ignored strobe yields rd_valid 0 and consumes no byte.
- R3: An accepted read yields rd_valid high and the byte on rd_data one clock after the strobe. Bytes leave in the order they were written. With a write and a read in every cycle, no slip ever occurs.
- R4: Separation is write count minus read count, modulo 64. It is taken at each accepted read, before that cycle's write lands. If it is 2 or less, the read position moves back 32 locations before the read. The frame is then repeated, and slip_repeat becomes 1.
- R5: If the separation at an accepted read is 42 or more, the read position moves forward 32 locations before the read. A frame is then skipped, and slip_repeat becomes 0.
- R6: slip_pulse is high for exactly the one cycle in which the slipped read's byte is presented with rd_valid. slip_repeat holds its value between slips.
- R7: The channel index (location modulo 32) of successive delivered bytes always advances by one, modulo 32, including across slips.
- R8: Separations from 3 to 41 never cause a slip. From the start-up separation of 10, eight reads with no writes cause no slip, and the ninth such read slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Line-side byte strobe |
| wr_data | input | 8 | Line-side channel byte |
| rd_en | input | 1 | System-side byte strobe |
| rd_data | output | 8 | Delivered channel byte |
| rd_valid | output | 1 | rd_data holds a newly delivered byte |
| slip_pulse | output | 1 | One-cycle marker of a slipped read |
| slip_repeat | output | 1 | Direction of last slip: 1 repeat, 0 skip |

## Verification
A write and a read can fall in the same cycle, and that read may also be the one that slips. The separation must then be judged on the pointer values from before the edge, and the write must not disturb the byte being read. The bench drives both strobes together through locked, slow-writer and fast-writer patterns, so slips land in cycles that also carry a write. A scoreboard model judges each read from the requirement rules, taking the read before the write, and compares data, valid, pulse and direction for every cycle.

// File: rtl/eb_pkg.sv
package eb_pkg;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

endpackage

// File: rtl/eb_store.sv
module eb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // registered read port; sees the value held before a same-edge write
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl #(
  parameter int AW        = 6,
  parameter int START_GAP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic          primed
);

  localparam logic [AW-1:0] LAST_FILL = AW'(START_GAP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr  <= '0;
      primed <= 1'b0;
    end else if (wr_en) begin
      waddr <= waddr + AW'(1);
      if (waddr == LAST_FILL) primed <= 1'b1;
    end
  end

  // R3: bytes are stored in strict arrival order
  a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> waddr == $past(waddr) + AW'(1));

  a_r2_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
  import eb_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CHANNELS = 32,
  parameter int LOW_TH   = 2,
  parameter int HIGH_TH  = 42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          primed,
  input  logic [AW-1:0] waddr,
  output logic          rd_fire,
  output logic [AW-1:0] eff_addr,
  output logic          rd_valid,
  output logic          slip_pulse,
  output logic          slip_repeat
);

  localparam int            CH_W   = $clog2(CHANNELS);
  localparam logic [AW-1:0] LOW_L  = AW'(LOW_TH);
  localparam logic [AW-1:0] HIGH_L = AW'(HIGH_TH);
  localparam logic [AW-1:0] FRAME  = AW'(CHANNELS);

  logic [AW-1:0] raddr;
  logic [AW-1:0] gap;
  slip_e         verdict;

  function automatic logic [AW-1:0] ptr_gap(input logic [AW-1:0] w, input logic [AW-1:0] r);
    return w - r;
  endfunction

  function automatic slip_e judge(input logic [AW-1:0] g);
    if (g <= LOW_L)  return SLIP_REPEAT;
    if (g >= HIGH_L) return SLIP_DROP;
    return SLIP_NONE;
  endfunction

  always_comb begin
    rd_fire = rd_en & primed;
    gap     = ptr_gap(waddr, raddr);
    verdict = rd_fire ? judge(gap) : SLIP_NONE;
    unique case (verdict)
      SLIP_REPEAT: eff_addr = raddr - FRAME;
      SLIP_DROP:   eff_addr = raddr + FRAME;
      default:     eff_addr = raddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raddr       <= '0;
      rd_valid    <= 1'b0;
      slip_pulse  <= 1'b0;
      slip_repeat <= 1'b0;
    end else begin
      rd_valid   <= rd_fire;
      slip_pulse <= (verdict != SLIP_NONE);
      if (rd_fire) raddr <= eff_addr + AW'(1);
      if (verdict == SLIP_REPEAT)   slip_repeat <= 1'b1;
      else if (verdict == SLIP_DROP) slip_repeat <= 1'b0;
    end
  end

  // R7: channel index steps by one on every accepted read, slips included
  a_r7_channel_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> raddr[CH_W-1:0] == $past(raddr[CH_W-1:0]) + CH_W'(1));

  // R4: a repeat slip moves the read position back by one frame
  a_r4_repeat_move: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && gap <= LOW_L) |=> (raddr + FRAME - AW'(1)) == $past(raddr));

  // R5: a drop slip moves the read position forward by one frame
  a_r5_drop_move: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && gap >= HIGH_L) |=> (raddr - FRAME - AW'(1)) == $past(raddr));

  // R8: inside the band no slip is flagged
  a_r8_band_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && gap > LOW_L && gap < HIGH_L) |=> !slip_pulse);

  // R6: slip marker only with delivered data; direction held otherwise
  a_r6_pulse_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> rd_valid);

  a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_pulse |-> $stable(slip_repeat));

endmodule

// File: rtl/elastic_slip_buffer.sv
module elastic_slip_buffer
  import eb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CHANNELS  = 32,
  parameter int FRAMES    = 2,
  parameter int LOW_TH    = 2,
  parameter int HIGH_TH   = 42,
  parameter int START_GAP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              slip_pulse,
  output logic              slip_repeat
);

  localparam int DEPTH = CHANNELS * FRAMES;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0] waddr;
  logic [AW-1:0] eff_addr;
  logic          primed;
  logic          rd_fire;

  eb_wr_ctrl #(.AW(AW), .START_GAP(START_GAP)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .waddr  (waddr),
    .primed (primed)
  );

  eb_rd_ctrl #(.AW(AW), .CHANNELS(CHANNELS), .LOW_TH(LOW_TH), .HIGH_TH(HIGH_TH)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .primed      (primed),
    .waddr       (waddr),
    .rd_fire     (rd_fire),
    .eff_addr    (eff_addr),
    .rd_valid    (rd_valid),
    .slip_pulse  (slip_pulse),
    .slip_repeat (slip_repeat)
  );

  eb_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (rd_fire),
    .raddr (eff_addr),
    .rdata (rd_data)
  );

  // R2: nothing is delivered before the buffer holds its start-up fill
  a_r2_prime_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !rd_valid);

  // R3: a delivered byte always follows an accepted strobe
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

endmodule

// File: tb/sim_elastic_slip_buffer.sv
module sim_elastic_slip_buffer;

  localparam int GAP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, slip_pulse, slip_repeat;

  always #5 clk = ~clk;

  elastic_slip_buffer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .slip_pulse(slip_pulse), .slip_repeat(slip_repeat)
  );

  typedef struct packed { logic vld; logic slip; logic rep; logic [7:0] data; } exp_t;
  exp_t expq[$];
  exp_t got;

  int vectors = 0, bad = 0;
  int m_wp = 0, m_rp = 0, wcnt = 0;
  bit m_primed = 0, m_dir = 0, done = 0;
  logic [7:0] m_mem [64];
  int obs_rep = 0, obs_drop = 0, last_ch = -1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of strobes and predicts its result
  task automatic step(bit we, bit re);
    exp_t e;
    int sep, at;
    @(negedge clk);
    wr_en = we; rd_en = re; wr_data = 8'(wcnt);
    e = '0;
    if (re && m_primed) begin
      sep = (m_wp - m_rp) & 63;
      at  = m_rp;
      if (sep <= 2)       begin at = (m_rp - 32) & 63; e.slip = 1; m_dir = 1; end
      else if (sep >= 42) begin at = (m_rp + 32) & 63; e.slip = 1; m_dir = 0; end
      e.vld  = 1;
      e.data = m_mem[at];
      m_rp   = (at + 1) & 63;
    end
    e.rep = m_dir;
    if (we) begin
      m_mem[m_wp] = 8'(wcnt);
      m_wp = (m_wp + 1) & 63;
      wcnt++;
      if (wcnt == GAP) m_primed = 1;
    end
    expq.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk); wr_en = 0; rd_en = 0;
    @(negedge clk);
  endtask

  // monitor: compares each cycle's outputs with the queued prediction
  always @(posedge clk) begin
    #1;
    if (rst_n && expq.size() > 0) begin
      got = expq.pop_front();
      check(rd_valid == got.vld, "R2", "rd_valid", rd_valid, got.vld);
      check(slip_pulse == got.slip, got.slip ? "R4" : "R6", "slip_pulse", slip_pulse, got.slip);
      check(slip_repeat == got.rep, "R6", "slip_repeat", slip_repeat, got.rep);
      if (got.vld) begin
        check(rd_data == got.data, "R3", "rd_data", rd_data, got.data);
        if (last_ch >= 0)
          check(int'(rd_data[4:0]) == ((last_ch + 1) % 32), "R7", "channel", rd_data[4:0], (last_ch + 1) % 32);
        last_ch = int'(rd_data[4:0]);
      end
      if (slip_pulse && slip_repeat)  obs_rep++;
      if (slip_pulse && !slip_repeat) obs_drop++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0, d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_valid == 0 && slip_pulse == 0, "R1", "flags in reset", {rd_valid, slip_pulse}, 0);
    check(slip_repeat == 0 && rd_data == 0, "R1", "dir/data in reset", {slip_repeat, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 0 && slip_pulse == 0 && rd_data == 0, "R1", "after release", rd_data, 0);

    // R2: reads issued during the start-up fill are ignored
    for (int i = 0; i < GAP; i++) step(1, 1);

    // R3: locked operation never slips
    r0 = obs_rep + obs_drop;
    for (int i = 0; i < 100; i++) step(1, 1);
    settle();
    check(obs_rep + obs_drop == r0, "R3", "slips while locked", obs_rep + obs_drop, r0);

    // R8: eight reads without writes stay inside tolerance
    r0 = obs_rep + obs_drop;
    for (int i = 0; i < 8; i++) step(0, 1);
    for (int i = 0; i < 8; i++) step(1, 0);
    settle();
    check(obs_rep + obs_drop == r0, "R8", "slips within jitter", obs_rep + obs_drop, r0);

    // R8 / R4: the ninth consecutive read repeats a frame
    r0 = obs_rep;
    for (int i = 0; i < 9; i++) step(0, 1);
    settle();
    check(obs_rep == r0 + 1, "R8", "ninth read slips", obs_rep, r0 + 1);
    for (int i = 0; i < 20; i++) step(1, 1);

    // R4: slow writer
    r0 = obs_rep;
    for (int i = 0; i < 150; i++) step(i % 3 != 0, 1);
    settle();
    check(obs_rep > r0, "R4", "repeat slips seen", obs_rep, r0 + 1);

    // R5: fast writer
    d0 = obs_drop;
    for (int i = 0; i < 200; i++) step(1, i % 3 != 0);
    settle();
    check(obs_drop > d0, "R5", "drop slips seen", obs_drop, d0 + 1);
    check(slip_repeat == 0, "R5", "direction after drop", slip_repeat, 0);

    // R6: locked again, direction bit holds
    for (int i = 0; i < 40; i++) step(1, 1);
    settle();
    check(slip_repeat == 0, "R6", "direction held", slip_repeat, 0);
    check(expq.size() == 0, "R3", "scoreboard drained", expq.size(), 0);
    finish_run();
  end

endmodule